// File: doc/BRIEF.md
# Sectored Wait-State External Memory Bus Master

This block drives a parallel external memory bus on behalf of an 8-bit CPU. It places the low address byte and the data byte on one shared bus. It drives the high address byte on its own pins. Three control lines go with them: an address latch enable (active high), a read strobe (active low) and a write strobe (active low). The CPU side issues one request at a time. A request carries a direction, a 16-bit address and, for a write, a data byte. Read data comes back with a one-cycle response pulse.

A configuration enable decides who owns the pins. While it is set, the block drives the shared pins and their output enables, whatever the normal port logic asks for. While it is clear, the port's own values and directions pass straight to the pads. The address space is cut into a lower and an upper sector at a point picked by a 3-bit limit. Each sector has a 2-bit wait setting that lengthens the strobe. The top wait setting also adds one cycle of address hold after the strobe.

Top module: `xmem_bus_master`

## Requirements
- R1: While `cfg_en` is 1, `pad_hi_oe` and `pad_ctl_oe` are all ones. When the bus is idle, `pad_ctl_out` is 3'b011 (bit 2 = ALE low, bit 1 = write strobe high, bit 0 = read strobe high) and `pad_ad_oe` is all zeros.
- R2: While `cfg_en` is 0, each pad output and output enable equals the matching `port_*` input, on all three pin groups.
- R3: If `cfg_limit` is 0, every address uses `cfg_ws_lo`. If `cfg_limit` is L between 1 and 7, addresses below L*8192 use `cfg_ws_lo` and all other addresses use `cfg_ws_hi`.
- R4: After a request is accepted, ALE is high for exactly one cycle. In that cycle `pad_ad_out` carries address bits 7:0 with `pad_ad_oe` all ones, `pad_hi_out` carries address bits 15:8, and both strobes are high. The strobe falls in the next cycle.
- R5: The strobe stays low for 1, 2, 3 or 3 cycles for wait settings 0, 1, 2 or 3.
- R6: Wait setting 3 adds exactly one cycle after the strobe rises. In that cycle both strobes are high, ALE is low, and `pad_hi_out` still holds the address. Settings 0 to 2 add no such cycle.
- R7: During a write strobe, `pad_ad_out` equals the write data and `pad_ad_oe` is all ones. The read strobe stays high, and `rsp_valid` does not pulse.
- R8: During a read strobe, `pad_ad_oe` is all zeros. `pad_ad_in` is sampled on the edge that ends the last strobe cycle. `rsp_valid` is high for one cycle, the cycle right after that edge, with `rsp_rdata` holding the sampled byte.
- R9: `req_ready` is 1 only when the bus is idle and `cfg_en` is 1. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. The next request can be taken 1 + strobe length + hold cycles after acceptance. Clearing `cfg_en` drops any access in progress and returns the bus to idle.
- R10: While reset is held, `rsp_valid` is 0 and the bus is idle, so R1's idle pin values apply when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Interface enable and pin ownership |
| cfg_limit | input | 3 | Sector split point in 8 KB units, 0 means no split |
| cfg_ws_lo | input | 2 | Wait setting for the lower sector |
| cfg_ws_hi | input | 2 | Wait setting for the upper sector |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Bus idle and able to accept a request |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| port_ad_out | input | 8 | Normal port value for the shared low byte pins |
| port_ad_oe | input | 8 | Normal port direction for the shared low byte pins |
| port_hi_out | input | 8 | Normal port value for the high address pins |
| port_hi_oe | input | 8 | Normal port direction for the high address pins |
| port_ctl_out | input | 3 | Normal port value for the control pins |
| port_ctl_oe | input | 3 | Normal port direction for the control pins |
| pad_ad_in | input | 8 | Value seen on the shared low byte pins |
| pad_ad_out | output | 8 | Driven value of the shared low byte pins |
| pad_ad_oe | output | 8 | Output enable of the shared low byte pins |
| pad_hi_out | output | 8 | Driven value of the high address pins |
| pad_hi_oe | output | 8 | Output enable of the high address pins |
| pad_ctl_out | output | 3 | Control pins: bit 2 ALE, bit 1 write strobe, bit 0 read strobe |
| pad_ctl_oe | output | 3 | Output enable of the control pins |

## Verification
The bench runs every split point against every pair of sector wait settings, for both directions. It uses addresses one below and exactly on the boundary. A sector compare that is off by one, or that treats a limit of zero as a split at zero, shows up as a wrong strobe length on one of those two addresses. The bench counts the ALE, strobe and hold cycles of each access separately. This catches a missing hold for the top setting, a strobe that is not clamped at two extra cycles, and a response sampled one cycle early or late. It also drops the enable in the middle of a stretched read. This exposes a design that leaves a strobe asserted, or fails to hand the pins back to the port.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
   typedef enum logic [1:0] {
      XM_IDLE   = 2'd0,
      XM_ADDR   = 2'd1,
      XM_STROBE = 2'd2,
      XM_HOLD   = 2'd3
   } xm_state_e;

   localparam int unsigned CTL_W   = 3;
   localparam int unsigned CTL_ALE = 2;
   localparam int unsigned CTL_WRN = 1;
   localparam int unsigned CTL_RDN = 0;
endpackage

// File: rtl/xmem_sector_sel.sv
module xmem_sector_sel #(
   parameter int unsigned LIMIT_W     = 3,
   parameter int unsigned WS_W        = 2,
   parameter int unsigned MAX_STRETCH = 2,
   parameter bit          SPLIT_EN    = 1'b1,
   localparam int unsigned CNT_W      = $clog2(MAX_STRETCH + 1)
) (
   input  logic [LIMIT_W-1:0] addr_top,
   input  logic [LIMIT_W-1:0] cfg_limit,
   input  logic [WS_W-1:0]    cfg_ws_lo,
   input  logic [WS_W-1:0]    cfg_ws_hi,
   output logic [CNT_W-1:0]   stretch,
   output logic               hold
);
   logic            in_upper;
   logic [WS_W-1:0] ws_sel;

   generate
      if (SPLIT_EN) begin : g_split
         assign in_upper = (cfg_limit != '0) && (addr_top >= cfg_limit);
      end else begin : g_flat
         logic unused_cfg;
         assign unused_cfg = ^{addr_top, cfg_limit, cfg_ws_hi};
         assign in_upper = 1'b0;
      end
   endgenerate

   assign ws_sel = in_upper ? cfg_ws_hi : cfg_ws_lo;

   always_comb begin
      if (int'(ws_sel) > int'(MAX_STRETCH)) stretch = CNT_W'(MAX_STRETCH);
      else                                 stretch = CNT_W'(ws_sel);
   end

   assign hold = (ws_sel == {WS_W{1'b1}});
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
   import xmem_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned MAX_STRETCH = 2,
   localparam int unsigned CNT_W      = $clog2(MAX_STRETCH + 1),
   localparam int unsigned HI_W       = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [CNT_W-1:0]  stretch_in,
   input  logic              hold_in,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic [DATA_W-1:0] bus_ad_in,
   output logic [DATA_W-1:0] bus_ad_out,
   output logic [DATA_W-1:0] bus_ad_oe,
   output logic [HI_W-1:0]   bus_hi_out,
   output logic [CTL_W-1:0]  bus_ctl_out
);
   xm_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              write_q;
   logic [CNT_W-1:0]  stretch_q;
   logic              hold_q;
   logic              ale, rd_n, wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= XM_IDLE;
         cnt       <= '0;
         addr_q    <= '0;
         wdata_q   <= '0;
         write_q   <= 1'b0;
         stretch_q <= '0;
         hold_q    <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (!enable) begin
            state <= XM_IDLE;
         end else begin
            unique case (state)
               XM_IDLE: if (req_valid) begin
                  addr_q    <= req_addr;
                  wdata_q   <= req_wdata;
                  write_q   <= req_write;
                  stretch_q <= stretch_in;
                  hold_q    <= hold_in;
                  state     <= XM_ADDR;
               end
               XM_ADDR: begin
                  cnt   <= '0;
                  state <= XM_STROBE;
               end
               XM_STROBE: begin
                  if (cnt == stretch_q) begin
                     if (!write_q) begin
                        rsp_rdata <= bus_ad_in;
                        rsp_valid <= 1'b1;
                     end
                     state <= hold_q ? XM_HOLD : XM_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= XM_IDLE;
            endcase
         end
      end
   end

   assign req_ready  = (state == XM_IDLE) && enable;
   assign ale        = (state == XM_ADDR);
   assign rd_n       = !((state == XM_STROBE) && !write_q);
   assign wr_n       = !((state == XM_STROBE) && write_q);
   assign bus_ad_out = (state == XM_STROBE) ? wdata_q : addr_q[DATA_W-1:0];
   assign bus_ad_oe  = (ale || !wr_n) ? {DATA_W{1'b1}} : '0;
   assign bus_hi_out = addr_q[ADDR_W-1:DATA_W];

   always_comb begin
      bus_ctl_out          = '0;
      bus_ctl_out[CTL_ALE] = ale;
      bus_ctl_out[CTL_WRN] = wr_n;
      bus_ctl_out[CTL_RDN] = rd_n;
   end

   p_ale_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wr_n));
   p_strobe_follows_ale_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n && wr_n) |-> $past(ale));
   p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));
   p_read_tristate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (bus_ad_oe == '0));
   p_rsp_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!rd_n));
   p_off_is_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (rd_n && wr_n && !ale));
endmodule

// File: rtl/xmem_pin_mux.sv
module xmem_pin_mux #(
   parameter int unsigned W = 8
) (
   input  logic         own,
   input  logic [W-1:0] bus_out,
   input  logic [W-1:0] bus_oe,
   input  logic [W-1:0] port_out,
   input  logic [W-1:0] port_oe,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe
);
   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign pad_out[b] = own ? bus_out[b] : port_out[b];
         assign pad_oe[b]  = own ? bus_oe[b]  : port_oe[b];
      end
   endgenerate
endmodule

// File: rtl/xmem_bus_master.sv
module xmem_bus_master
   import xmem_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned LIMIT_W     = 3,
   parameter int unsigned WS_W        = 2,
   parameter int unsigned MAX_STRETCH = 2,
   parameter bit          SPLIT_EN    = 1'b1,
   localparam int unsigned HI_W       = ADDR_W - DATA_W,
   localparam int unsigned CNT_W      = $clog2(MAX_STRETCH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [LIMIT_W-1:0] cfg_limit,
   input  logic [WS_W-1:0]   cfg_ws_lo,
   input  logic [WS_W-1:0]   cfg_ws_hi,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic [DATA_W-1:0] port_ad_out,
   input  logic [DATA_W-1:0] port_ad_oe,
   input  logic [HI_W-1:0]   port_hi_out,
   input  logic [HI_W-1:0]   port_hi_oe,
   input  logic [CTL_W-1:0]  port_ctl_out,
   input  logic [CTL_W-1:0]  port_ctl_oe,
   input  logic [DATA_W-1:0] pad_ad_in,
   output logic [DATA_W-1:0] pad_ad_out,
   output logic [DATA_W-1:0] pad_ad_oe,
   output logic [HI_W-1:0]   pad_hi_out,
   output logic [HI_W-1:0]   pad_hi_oe,
   output logic [CTL_W-1:0]  pad_ctl_out,
   output logic [CTL_W-1:0]  pad_ctl_oe
);
   generate
      if (ADDR_W <= DATA_W) begin : g_bad_width
         $error("xmem_bus_master: ADDR_W must exceed DATA_W");
      end
      if (LIMIT_W == 0 || LIMIT_W > ADDR_W) begin : g_bad_limit
         $error("xmem_bus_master: LIMIT_W out of range");
      end
      if (MAX_STRETCH < 1) begin : g_bad_stretch
         $error("xmem_bus_master: MAX_STRETCH must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]  stretch;
   logic              hold;
   logic [DATA_W-1:0] bus_ad_out, bus_ad_oe;
   logic [HI_W-1:0]   bus_hi_out;
   logic [CTL_W-1:0]  bus_ctl_out;

   xmem_sector_sel #(
      .LIMIT_W(LIMIT_W), .WS_W(WS_W), .MAX_STRETCH(MAX_STRETCH), .SPLIT_EN(SPLIT_EN)
   ) u_sector (
      .addr_top (req_addr[ADDR_W-1 -: LIMIT_W]),
      .cfg_limit(cfg_limit),
      .cfg_ws_lo(cfg_ws_lo),
      .cfg_ws_hi(cfg_ws_hi),
      .stretch  (stretch),
      .hold     (hold)
   );

   xmem_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_STRETCH(MAX_STRETCH)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (cfg_en),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .stretch_in (stretch),
      .hold_in    (hold),
      .req_ready  (req_ready),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata),
      .bus_ad_in  (pad_ad_in),
      .bus_ad_out (bus_ad_out),
      .bus_ad_oe  (bus_ad_oe),
      .bus_hi_out (bus_hi_out),
      .bus_ctl_out(bus_ctl_out)
   );

   xmem_pin_mux #(.W(DATA_W)) u_mux_ad (
      .own(cfg_en), .bus_out(bus_ad_out), .bus_oe(bus_ad_oe),
      .port_out(port_ad_out), .port_oe(port_ad_oe),
      .pad_out(pad_ad_out), .pad_oe(pad_ad_oe)
   );

   xmem_pin_mux #(.W(HI_W)) u_mux_hi (
      .own(cfg_en), .bus_out(bus_hi_out), .bus_oe({HI_W{1'b1}}),
      .port_out(port_hi_out), .port_oe(port_hi_oe),
      .pad_out(pad_hi_out), .pad_oe(pad_hi_oe)
   );

   xmem_pin_mux #(.W(CTL_W)) u_mux_ctl (
      .own(cfg_en), .bus_out(bus_ctl_out), .bus_oe({CTL_W{1'b1}}),
      .port_out(port_ctl_out), .port_oe(port_ctl_oe),
      .pad_out(pad_ctl_out), .pad_oe(pad_ctl_oe)
   );

   p_pins_owned_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |-> (pad_hi_oe == {HI_W{1'b1}} && pad_ctl_oe == {CTL_W{1'b1}}));
   p_pins_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |-> (pad_ad_oe == port_ad_oe && pad_hi_out == port_hi_out &&
                   pad_ctl_out == port_ctl_out));
   p_ready_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> cfg_en);
endmodule

// File: tb/xmem_bus_master_tb.sv
`timescale 1ns/1ps
module xmem_bus_master_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_en = 1'b0;
   logic [2:0] cfg_limit = '0;
   logic [1:0] cfg_ws_lo = '0, cfg_ws_hi = '0;
   logic       req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       req_ready, rsp_valid;
   logic [7:0] rsp_rdata;
   logic [7:0] port_ad_out = '0, port_ad_oe = '0, port_hi_out = '0, port_hi_oe = '0;
   logic [2:0] port_ctl_out = '0, port_ctl_oe = '0;
   logic [7:0] pad_ad_in = '0;
   logic [7:0] pad_ad_out, pad_ad_oe, pad_hi_out, pad_hi_oe;
   logic [2:0] pad_ctl_out, pad_ctl_oe;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   xmem_bus_master u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_limit(cfg_limit),
      .cfg_ws_lo(cfg_ws_lo), .cfg_ws_hi(cfg_ws_hi),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata),
      .port_ad_out(port_ad_out), .port_ad_oe(port_ad_oe),
      .port_hi_out(port_hi_out), .port_hi_oe(port_hi_oe),
      .port_ctl_out(port_ctl_out), .port_ctl_oe(port_ctl_oe),
      .pad_ad_in(pad_ad_in), .pad_ad_out(pad_ad_out), .pad_ad_oe(pad_ad_oe),
      .pad_hi_out(pad_hi_out), .pad_hi_oe(pad_hi_oe),
      .pad_ctl_out(pad_ctl_out), .pad_ctl_oe(pad_ctl_oe)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int ws_for(input logic [15:0] a);
      if (cfg_limit != 0 && int'(a) >= int'(cfg_limit) * 8192) return int'(cfg_ws_hi);
      return int'(cfg_ws_lo);
   endfunction

   task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d);
      int ws, s_exp, h_exp;
      int n_ale, n_str, n_hold, busy, rsp_at;
      logic [7:0] rpat;
      ws    = ws_for(a);
      s_exp = 1 + ((ws > 2) ? 2 : ws);
      h_exp = (ws == 3) ? 1 : 0;
      rpat  = a[7:0] ^ 8'hA5;
      @(negedge clk);
      check(req_ready == 1'b1, "R9 ready before request", int'(req_ready), 1);
      check(pad_ctl_out == 3'b011 && pad_ad_oe == 8'h00, "R1 idle pins",
            int'({pad_ctl_out, pad_ad_oe}), 'h300);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; pad_ad_in = rpat;
      @(negedge clk);
      req_valid = 1'b0;
      n_ale = 0; n_str = 0; n_hold = 0; busy = 0; rsp_at = -1;
      for (int i = 0; i < 10; i++) begin
         if (rsp_valid) begin
            rsp_at = i;
            check(rsp_rdata == rpat, "R8 read data", int'(rsp_rdata), int'(rpat));
         end
         if (req_ready) break;
         busy++;
         if (pad_ctl_out[2]) begin
            n_ale++;
            check(pad_ad_out == a[7:0] && pad_ad_oe == 8'hFF, "R4 low address on bus",
                  int'(pad_ad_out), int'(a[7:0]));
            check(pad_hi_out == a[15:8], "R4 high address", int'(pad_hi_out), int'(a[15:8]));
            check(pad_ctl_out[1:0] == 2'b11, "R4 strobes high under ALE",
                  int'(pad_ctl_out), 'h7);
         end else if (w ? !pad_ctl_out[1] : !pad_ctl_out[0]) begin
            n_str++;
            check(n_ale == 1, "R4 strobe after ALE", n_ale, 1);
            if (w) begin
               check(pad_ad_out == d && pad_ad_oe == 8'hFF, "R7 write data driven",
                     int'(pad_ad_out), int'(d));
               check(pad_ctl_out[0], "R7 read strobe idle", 0, 1);
            end else begin
               check(pad_ad_oe == 8'h00, "R8 bus tristated", int'(pad_ad_oe), 0);
               check(pad_ctl_out[1], "R8 write strobe idle", 0, 1);
            end
         end else begin
            n_hold++;
            check(pad_ctl_out == 3'b011 && pad_hi_out == a[15:8], "R6 hold cycle pins",
                  int'(pad_hi_out), int'(a[15:8]));
         end
         @(negedge clk);
      end
      check(n_ale == 1, "R4 ALE length", n_ale, 1);
      check(n_str == s_exp, "R3 R5 strobe length", n_str, s_exp);
      check(n_hold == h_exp, "R6 hold cycles", n_hold, h_exp);
      check(busy == 1 + s_exp + h_exp, "R9 busy cycles", busy, 1 + s_exp + h_exp);
      check(rsp_at == (w ? -1 : 1 + s_exp), "R8 R7 response timing", rsp_at,
            w ? -1 : 1 + s_exp);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] addrs [4];
      cfg_en = 1'b1;
      repeat (3) @(negedge clk);
      check(rsp_valid == 1'b0, "R10 no response in reset", int'(rsp_valid), 0);
      check(pad_ctl_out == 3'b011, "R10 idle control in reset", int'(pad_ctl_out), 3);
      check(pad_ad_oe == 8'h00, "R10 bus released in reset", int'(pad_ad_oe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(pad_hi_oe == 8'hFF && pad_ctl_oe == 3'h7, "R1 pins owned",
            int'({pad_hi_oe, pad_ctl_oe}), 'h7FF);
      port_ad_oe = 8'hFF; port_ctl_out = 3'b100; port_hi_oe = 8'h00;
      @(negedge clk);
      check(pad_ad_oe == 8'h00 && pad_ctl_out == 3'b011 && pad_hi_oe == 8'hFF,
            "R1 enable overrides port direction", int'(pad_ad_oe), 0);

      // R2: pins follow the port when disabled
      cfg_en = 1'b0;
      for (int k = 0; k < 8; k++) begin
         port_ad_out = 8'(k * 37); port_ad_oe = 8'(~(k * 11));
         port_hi_out = 8'(k * 53 + 1); port_hi_oe = 8'(k * 29);
         port_ctl_out = 3'(k); port_ctl_oe = 3'(~k);
         @(negedge clk);
         check(pad_ad_out == port_ad_out && pad_ad_oe == port_ad_oe, "R2 low byte pins",
               int'(pad_ad_out), int'(port_ad_out));
         check(pad_hi_out == port_hi_out && pad_hi_oe == port_hi_oe, "R2 high pins",
               int'(pad_hi_out), int'(port_hi_out));
         check(pad_ctl_out == port_ctl_out && pad_ctl_oe == port_ctl_oe, "R2 control pins",
               int'(pad_ctl_out), int'(port_ctl_out));
         check(req_ready == 1'b0, "R9 not ready when disabled", int'(req_ready), 0);
      end
      cfg_en = 1'b1;

      // R3 R5 R6 R7 R8: sweep split points and sector wait settings
      for (int lim = 0; lim < 8; lim++) begin
         for (int lo = 0; lo < 4; lo++) begin
            for (int hi = 0; hi < 4; hi++) begin
               cfg_limit = 3'(lim); cfg_ws_lo = 2'(lo); cfg_ws_hi = 2'(hi);
               addrs[0] = 16'h0000;
               addrs[1] = 16'hFFFF;
               addrs[2] = (lim == 0) ? 16'h7FFF : 16'(lim * 8192 - 1);
               addrs[3] = (lim == 0) ? 16'h8000 : 16'(lim * 8192);
               for (int j = 0; j < 4; j++) begin
                  access(1'b0, addrs[j], 8'h00);
                  access(1'b1, addrs[j], 8'(addrs[j][7:0] ^ 8'h3C ^ 8'(j)));
               end
            end
         end
      end

      // R9: dropping the enable in the middle of a stretched read
      cfg_limit = 3'd0; cfg_ws_lo = 2'd3;
      port_ctl_out = 3'b101; port_ctl_oe = 3'b010;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h1234;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check(pad_ctl_out[0] == 1'b0, "R9 read strobe active before drop",
            int'(pad_ctl_out), 2);
      cfg_en = 1'b0;
      @(negedge clk);
      check(pad_ctl_out == 3'b101 && pad_ctl_oe == 3'b010, "R2 pins returned mid access",
            int'(pad_ctl_out), 5);
      check(req_ready == 1'b0, "R9 no ready while disabled", int'(req_ready), 0);
      cfg_en = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && pad_ctl_out == 3'b011, "R9 aborted access left idle",
            int'({req_ready, pad_ctl_out}), 'hB);
      check(rsp_valid == 1'b0, "R9 no response from aborted read", int'(rsp_valid), 0);
      access(1'b0, 16'h4321, 8'h00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule